// File: doc/BRIEF.md
# Type B Card Select and Exchange Sequencer

This block is the reader-side controller that brings a single proximity card of the Type B family into the active state and then carries block-numbered data frames to it. It does not touch the air interface. It hands frames to a byte-level transmitter through a valid/ready stream that ends with a last-byte flag, and waits for that transmitter's completion strobe. It then takes the answer from a receiver, which reports a length and lets the sequencer read the received bytes by index.

A selection request sends the fixed wake-up frame. The block then takes the card identifier and the protocol-type nibble from the identification answer and builds the attribute command around them, with a computed CRC. It judges both answers by length alone and reports a completion code. An exchange request wraps a payload, fetched by index from the requester's buffer, in a data frame. That frame carries a one-bit block number, which toggles after each data frame and is cleared by every successful selection. The block reports the answer length, or zero when the answer is too short.

Top module: `typeb_select_seq`

## Requirements
- R1: After reset, busy_o, done_o and tx_valid_o are 0, status_o is 0 and resp_len_o is 0.
- R2: A start with op_i=0 (select) transmits exactly the five bytes 05 00 08 39 73, with tx_last_o on the fifth, and no CRC appended.
- R3: An identification answer of fewer than 14 bytes ends selection with a done_o pulse and status_o=2, and no attribute frame is sent.
- R4: The attribute frame is 11 bytes: byte 0 is 1D, bytes 1 to 4 copy answer bytes 1 to 4, byte 5 is 00, byte 6 is 08, byte 7 is answer byte 10 AND 0x0F, byte 8 is 00, bytes 9 and 10 are the CRC of bytes 0 to 8.
- R5: The appended CRC uses the reflected polynomial 0x8408, starts at 0xFFFF, is complemented at the end and is sent low byte first.
- R6: An attribute answer of fewer than 3 bytes gives status_o=2 and leaves the block number unchanged; 3 or more bytes gives status_o=1 and clears the block number to 0.
- R7: A start with op_i=1 (exchange) transmits byte 0 = 0x0A OR block number, byte 1 = 00, then the payload bytes in index order, then the 2-byte CRC over all preceding bytes.
- R8: The block number toggles after each data frame is transmitted.
- R9: After an exchange, resp_len_o is 0 if the answer has fewer than 3 bytes and the received length otherwise; a receive timeout counts as a zero-length answer.
- R10: A payload length above 60 is treated as 60.
- R11: A start request while busy_o is 1 is ignored: the running operation completes unchanged and no further frame follows it.
- R12: When rx_valid_i and rx_timeout_i are high in the same cycle, the frame and its length take priority.
- R13: While tx_valid_o is 1 and tx_ready_i is 0, tx_byte_o and tx_last_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| op_i | input | 1 | 0 = select, 1 = exchange |
| pay_len_i | input | 8 | Payload length for exchange |
| pay_rd_idx_o | output | 8 | Payload byte index being read |
| pay_rd_data_i | input | 8 | Payload byte at pay_rd_idx_o |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Transmitter accepts byte |
| tx_byte_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Last byte of frame |
| tx_done_i | input | 1 | Frame has left the transmitter |
| rx_valid_i | input | 1 | Answer frame received |
| rx_timeout_i | input | 1 | No answer within the receive window |
| rx_len_i | input | 8 | Received answer length |
| rx_idx_o | output | 8 | Received byte index being read |
| rx_byte_i | input | 8 | Received byte at rx_idx_o |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Selection result: 1 success, 2 failure |
| resp_len_o | output | 8 | Reported exchange answer length |

## Verification
Two receive-side events can land on the same clock edge: a completed answer frame and the expiry of the receive window. The bench raises rx_valid_i and rx_timeout_i together with a length of 5 during an exchange. It expects resp_len_o to read 5, not the zero that a timeout alone would give. Start requests that arrive while the sequencer waits for transmit completion are also driven, and the bench checks that the block returns to idle with no extra frame.

// File: rtl/typeb_seq_pkg.sv
package typeb_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_TXWAIT,
        ST_RXWAIT,
        ST_GRAB
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_WAKE,
        PH_ATTR,
        PH_DATA
    } seq_phase_e;

    localparam logic [1:0] CODE_NONE = 2'd0;
    localparam logic [1:0] CODE_OK   = 2'd1;
    localparam logic [1:0] CODE_FAIL = 2'd2;

    localparam logic       OP_SELECT   = 1'b0;
    localparam logic       OP_EXCHANGE = 1'b1;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;

endpackage

// File: rtl/typeb_crc_unit.sv
module typeb_crc_unit #(
    parameter logic [15:0] POLY = 16'h8408
) (
    input  logic [15:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);
    logic [15:0] acc;

    always_comb begin
        acc = crc_i ^ {8'h00, byte_i};
        for (int b = 0; b < 8; b++) begin
            if (acc[0]) acc = (acc >> 1) ^ POLY;
            else        acc = acc >> 1;
        end
        crc_o = acc;
    end
endmodule

// File: rtl/typeb_frame_mux.sv
module typeb_frame_mux
    import typeb_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  seq_phase_e        phase_i,
    input  logic [LEN_W-1:0]  idx_i,
    input  logic [LEN_W-1:0]  flen_i,
    input  logic              blk_i,
    input  logic [3:0][7:0]   ident_i,
    input  logic [3:0]        proto_i,
    input  logic [7:0]        pay_i,
    input  logic [15:0]       crc_i,
    output logic [7:0]        byte_o
);
    logic [15:0] fcs;
    logic        at_lo;
    logic        at_hi;

    assign fcs   = ~crc_i;
    assign at_lo = (idx_i == flen_i - LEN_W'(2));
    assign at_hi = (idx_i == flen_i - LEN_W'(1));

    always_comb begin
        byte_o = 8'h00;
        unique case (phase_i)
            PH_WAKE: begin
                unique case (idx_i)
                    LEN_W'(0): byte_o = 8'h05;
                    LEN_W'(1): byte_o = 8'h00;
                    LEN_W'(2): byte_o = 8'h08;
                    LEN_W'(3): byte_o = 8'h39;
                    LEN_W'(4): byte_o = 8'h73;
                    default:   byte_o = 8'h00;
                endcase
            end
            PH_ATTR: begin
                if (at_lo)      byte_o = fcs[7:0];
                else if (at_hi) byte_o = fcs[15:8];
                else begin
                    unique case (idx_i)
                        LEN_W'(0): byte_o = 8'h1D;
                        LEN_W'(1): byte_o = ident_i[0];
                        LEN_W'(2): byte_o = ident_i[1];
                        LEN_W'(3): byte_o = ident_i[2];
                        LEN_W'(4): byte_o = ident_i[3];
                        LEN_W'(6): byte_o = 8'h08;
                        LEN_W'(7): byte_o = {4'h0, proto_i};
                        default:   byte_o = 8'h00;
                    endcase
                end
            end
            default: begin
                if (at_lo)                   byte_o = fcs[7:0];
                else if (at_hi)              byte_o = fcs[15:8];
                else if (idx_i == LEN_W'(0)) byte_o = {7'b0000101, blk_i};
                else if (idx_i == LEN_W'(1)) byte_o = 8'h00;
                else                         byte_o = pay_i;
            end
        endcase
    end
endmodule

// File: rtl/typeb_select_seq.sv
module typeb_select_seq
    import typeb_seq_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int MAX_PAY = 60,
    parameter int ID_MIN  = 14,
    parameter int ANS_MIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_i,
    input  logic [LEN_W-1:0] pay_len_i,
    output logic [LEN_W-1:0] pay_rd_idx_o,
    input  logic [7:0]       pay_rd_data_i,
    output logic             tx_valid_o,
    input  logic             tx_ready_i,
    output logic [7:0]       tx_byte_o,
    output logic             tx_last_o,
    input  logic             tx_done_i,
    input  logic             rx_valid_i,
    input  logic             rx_timeout_i,
    input  logic [LEN_W-1:0] rx_len_i,
    output logic [LEN_W-1:0] rx_idx_o,
    input  logic [7:0]       rx_byte_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       status_o,
    output logic [LEN_W-1:0] resp_len_o
);
    localparam int              OVERHEAD  = 4;
    localparam logic [LEN_W-1:0] WAKE_LEN = LEN_W'(5);
    localparam logic [LEN_W-1:0] ATTR_LEN = LEN_W'(11);
    localparam logic [LEN_W-1:0] PAY_CAP  = LEN_W'(MAX_PAY);
    localparam logic [LEN_W-1:0] ID_IDX   = LEN_W'(10);
    localparam int              GRAB_N    = 5;
    localparam int              GRAB_W    = $clog2(GRAB_N + 1);

    typedef struct packed {
        seq_state_e       st;
        seq_phase_e       ph;
        logic [LEN_W-1:0] idx;
        logic [LEN_W-1:0] flen;
        logic [15:0]      crc;
        logic             blk;
        logic [3:0][7:0]  ident;
        logic [3:0]       proto;
        logic [GRAB_W-1:0] grab;
        logic [1:0]       status;
        logic [LEN_W-1:0] resp;
        logic             done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [15:0]      crc_step;
    logic [7:0]       frame_byte;
    logic [LEN_W-1:0] pay_eff;
    logic [LEN_W-1:0] ans_len;
    logic             ans_seen;
    logic             last_byte;
    logic             body_byte;

    typeb_crc_unit #(.POLY(16'h8408)) u_crc (
        .crc_i  (r_q.crc),
        .byte_i (frame_byte),
        .crc_o  (crc_step)
    );

    typeb_frame_mux #(.LEN_W(LEN_W)) u_mux (
        .phase_i (r_q.ph),
        .idx_i   (r_q.idx),
        .flen_i  (r_q.flen),
        .blk_i   (r_q.blk),
        .ident_i (r_q.ident),
        .proto_i (r_q.proto),
        .pay_i   (pay_rd_data_i),
        .crc_i   (r_q.crc),
        .byte_o  (frame_byte)
    );

    assign pay_eff   = (pay_len_i > PAY_CAP) ? PAY_CAP : pay_len_i;
    assign ans_seen  = rx_valid_i | rx_timeout_i;
    assign ans_len   = rx_valid_i ? rx_len_i : '0;
    assign last_byte = (r_q.idx == r_q.flen - LEN_W'(1));
    assign body_byte = (r_q.idx < r_q.flen - LEN_W'(2));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st  = ST_SEND;
                    r_d.idx = '0;
                    r_d.crc = CRC_SEED;
                    if (op_i == OP_SELECT) begin
                        r_d.ph   = PH_WAKE;
                        r_d.flen = WAKE_LEN;
                    end else begin
                        r_d.ph   = PH_DATA;
                        r_d.flen = pay_eff + LEN_W'(OVERHEAD);
                    end
                end
            end
            ST_SEND: begin
                if (tx_ready_i) begin
                    if (body_byte) r_d.crc = crc_step;
                    r_d.idx = r_q.idx + LEN_W'(1);
                    if (last_byte) begin
                        r_d.st = ST_TXWAIT;
                        if (r_q.ph == PH_DATA) r_d.blk = ~r_q.blk;
                    end
                end
            end
            ST_TXWAIT: begin
                if (tx_done_i) r_d.st = ST_RXWAIT;
            end
            ST_RXWAIT: begin
                if (ans_seen) begin
                    unique case (r_q.ph)
                        PH_WAKE: begin
                            if (ans_len < LEN_W'(ID_MIN)) begin
                                r_d.st     = ST_IDLE;
                                r_d.status = CODE_FAIL;
                                r_d.done   = 1'b1;
                            end else begin
                                r_d.st   = ST_GRAB;
                                r_d.grab = '0;
                            end
                        end
                        PH_ATTR: begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                            if (ans_len < LEN_W'(ANS_MIN)) begin
                                r_d.status = CODE_FAIL;
                            end else begin
                                r_d.status = CODE_OK;
                                r_d.blk    = 1'b0;
                            end
                        end
                        default: begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                            r_d.resp = (ans_len < LEN_W'(ANS_MIN)) ? '0 : ans_len;
                        end
                    endcase
                end
            end
            ST_GRAB: begin
                r_d.grab = r_q.grab + GRAB_W'(1);
                if (r_q.grab < GRAB_W'(GRAB_N - 1)) begin
                    r_d.ident[r_q.grab[1:0]] = rx_byte_i;
                end else begin
                    r_d.proto = rx_byte_i[3:0];
                    r_d.st    = ST_SEND;
                    r_d.ph    = PH_ATTR;
                    r_d.idx   = '0;
                    r_d.flen  = ATTR_LEN;
                    r_d.crc   = CRC_SEED;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ph: PH_WAKE, crc: CRC_SEED, status: CODE_NONE,
                     default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_valid_o   = (r_q.st == ST_SEND);
    assign tx_byte_o    = frame_byte;
    assign tx_last_o    = tx_valid_o && last_byte;
    assign pay_rd_idx_o = r_q.idx - LEN_W'(2);
    assign rx_idx_o     = (r_q.grab == GRAB_W'(GRAB_N - 1)) ? ID_IDX
                                                            : LEN_W'(r_q.grab) + LEN_W'(1);
    assign busy_o       = (r_q.st != ST_IDLE);
    assign done_o       = r_q.done;
    assign status_o     = r_q.status;
    assign resp_len_o   = r_q.resp;
endmodule

// File: rtl/typeb_select_seq_chk.sv
module typeb_select_seq_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [1:0]       status_o,
    input logic [LEN_W-1:0] resp_len_o,
    input logic             tx_valid_o,
    input logic             tx_ready_i,
    input logic [7:0]       tx_byte_o,
    input logic             tx_last_o
);
    assert_tx_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_byte_o) && $stable(tx_last_o)));

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_idle_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !tx_valid_o);

    assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status_o != 2'd3);

    assert_short_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_len_o == '0) || (resp_len_o >= LEN_W'(3)));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_last_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last_o |-> tx_valid_o);
endmodule

bind typeb_select_seq typeb_select_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .status_o   (status_o),
    .resp_len_o (resp_len_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_byte_o  (tx_byte_o),
    .tx_last_o  (tx_last_o)
);

// File: tb/typeb_select_seq_tb.sv
module typeb_select_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       op_i = 1'b0;
    logic [7:0] pay_len_i = '0;
    logic [7:0] pay_rd_idx_o;
    logic [7:0] pay_rd_data_i;
    logic       tx_valid_o;
    logic       tx_ready_i = 1'b0;
    logic [7:0] tx_byte_o;
    logic       tx_last_o;
    logic       tx_done_i = 1'b0;
    logic       rx_valid_i = 1'b0;
    logic       rx_timeout_i = 1'b0;
    logic [7:0] rx_len_i = '0;
    logic [7:0] rx_idx_o;
    logic [7:0] rx_byte_i;
    logic       busy_o, done_o;
    logic [1:0] status_o;
    logic [7:0] resp_len_o;

    always #10 clk = ~clk;

    logic [7:0] pay [0:255];
    logic [7:0] rxb [0:255];
    logic [7:0] fr  [0:255];
    assign pay_rd_data_i = pay[pay_rd_idx_o];
    assign rx_byte_i     = rxb[rx_idx_o];

    typeb_select_seq u_dut (.*);

    int nchk = 0;
    int nbad = 0;
    int hold_err = 0;
    bit finished = 0;
    logic exp_blk = 1'b0;

    // plen, alen, timeout, expected resp_len
    localparam logic [24:0] VEC [0:5] = '{
        {8'd4,  8'd6,  1'b0, 8'd6},
        {8'd0,  8'd2,  1'b0, 8'd0},
        {8'd1,  8'd3,  1'b0, 8'd3},
        {8'd60, 8'd20, 1'b0, 8'd20},
        {8'd63, 8'd9,  1'b0, 8'd9},
        {8'd7,  8'd0,  1'b1, 8'd0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_of(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {8'h00, fr[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic do_start(input logic op, input logic [7:0] plen);
        @(negedge clk);
        start_i = 1'b1; op_i = op; pay_len_i = plen;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic collect(output int n);
        logic [7:0] held = '0;
        bit have = 0;
        n = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            tx_ready_i = (k % 3 != 1);
            #1;
            if (tx_valid_o) begin
                if (!tx_ready_i) begin
                    held = tx_byte_o; have = 1;
                end else begin
                    if (have && tx_byte_o != held) hold_err++;
                    have = 0;
                    fr[n] = tx_byte_o;
                    n++;
                    if (tx_last_o) break;
                end
            end
        end
    endtask

    // after the final negedge, done_o may already be high
    task automatic answer(input logic [7:0] len, input bit tmo, input bit frm);
        @(negedge clk);
        tx_ready_i = 1'b0; tx_done_i = 1'b1;
        @(negedge clk);
        tx_done_i = 1'b0;
        @(negedge clk);
        rx_valid_i = frm; rx_timeout_i = tmo; rx_len_i = len;
        @(negedge clk);
        rx_valid_i = 1'b0; rx_timeout_i = 1'b0;
    endtask

    // 1 = done seen, 2 = a new frame started, 0 = neither
    task automatic poll(output int what);
        what = 0;
        for (int k = 0; k < 40; k++) begin
            #1;
            if (done_o) begin what = 1; return; end
            if (tx_valid_o) begin what = 2; return; end
            @(negedge clk);
        end
    endtask

    task automatic exchange(input logic [7:0] plen, input logic [7:0] alen, input bit tmo,
                            input logic [7:0] exp, input string tag);
        int n, w, pe;
        do_start(1'b1, plen);
        collect(n);
        pe = (plen > 60) ? 60 : int'(plen);
        check(n == pe + 4, {tag, " R7 R10 frame length"}, n, pe + 4);
        check(fr[0] == {7'b0000101, exp_blk}, {tag, " R7 R8 control byte"}, fr[0], {7'b0000101, exp_blk});
        check(fr[1] == 8'h00, {tag, " R7 identifier byte"}, fr[1], 0);
        for (int i = 0; i < pe; i++)
            if (fr[2 + i] != pay[i]) check(1'b0, {tag, " R7 payload"}, fr[2 + i], pay[i]);
        check({fr[pe + 3], fr[pe + 2]} == crc_of(pe + 2), {tag, " R5 R7 crc"},
              {fr[pe + 3], fr[pe + 2]}, crc_of(pe + 2));
        exp_blk = ~exp_blk;
        answer(alen, tmo, !tmo);
        poll(w);
        check(w == 1, {tag, " R9 done"}, w, 1);
        check(resp_len_o == exp, {tag, " R9 resp length"}, resp_len_o, exp);
    endtask

    task automatic fill_ident();
        for (int i = 0; i < 32; i++) rxb[i] = 8'h90 + 8'(i);
        rxb[0] = 8'h50; rxb[1] = 8'hAB; rxb[2] = 8'hCD; rxb[3] = 8'hEF; rxb[4] = 8'h12;
        rxb[10] = 8'h7C;
    endtask

    task automatic select_seq(input logic [7:0] id_len, input logic [7:0] at_len,
                              input logic [1:0] exp_code, input string tag);
        int n, w;
        do_start(1'b0, 8'd0);
        collect(n);
        check(n == 5 && fr[0] == 8'h05 && fr[1] == 8'h00 && fr[2] == 8'h08 &&
              fr[3] == 8'h39 && fr[4] == 8'h73, {tag, " R2 wake-up frame"},
              {fr[0], fr[1], fr[2], fr[3], fr[4]}, 40'h0500083973);
        answer(id_len, 1'b0, 1'b1);
        poll(w);
        if (id_len < 14) begin
            check(w == 1, {tag, " R3 no attribute after short answer"}, w, 1);
            check(status_o == 2'd2, {tag, " R3 failure code"}, status_o, 2);
            return;
        end
        check(w == 2, {tag, " R4 attribute frame starts"}, w, 2);
        collect(n);
        check(n == 11, {tag, " R4 attribute length"}, n, 11);
        check(fr[0] == 8'h1D && fr[1] == 8'hAB && fr[2] == 8'hCD && fr[3] == 8'hEF &&
              fr[4] == 8'h12 && fr[5] == 8'h00 && fr[6] == 8'h08 && fr[7] == 8'h0C &&
              fr[8] == 8'h00, {tag, " R4 attribute body"}, {fr[0], fr[7]}, 16'h1D0C);
        check({fr[10], fr[9]} == crc_of(9), {tag, " R5 attribute crc"},
              {fr[10], fr[9]}, crc_of(9));
        answer(at_len, 1'b0, 1'b1);
        poll(w);
        check(w == 1 && status_o == exp_code, {tag, " R6 selection code"}, status_o, exp_code);
        if (exp_code == 2'd1) exp_blk = 1'b0;
    endtask

    initial begin
        int w;
        for (int i = 0; i < 256; i++) begin
            pay[i] = 8'h30 + 8'(i * 7);
            rxb[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        #1;
        check(!busy_o && !done_o && !tx_valid_o && status_o == 0 && resp_len_o == 0,
              "R1 reset state", {busy_o, done_o, tx_valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!busy_o && !tx_valid_o && status_o == 0 && resp_len_o == 0,
              "R1 after release", {busy_o, tx_valid_o, status_o}, 0);

        for (int v = 0; v < 6; v++) begin
            logic [24:0] e = VEC[v];
            exchange(e[24:17], e[16:9], e[8], e[7:0], "vector");
        end

        // one more frame: block number becomes 1
        exchange(8'd2, 8'd4, 1'b0, 8'd4, "R8 pre-select");
        // short identification answer, timeout style
        fill_ident();
        select_seq(8'd13, 8'd0, 2'd2, "R3 short ident");
        // attribute answer too short: block number kept (R6)
        select_seq(8'd14, 8'd2, 2'd2, "R6 short attrib");
        exchange(8'd3, 8'd5, 1'b0, 8'd5, "R6 block kept");
        exchange(8'd3, 8'd5, 1'b0, 8'd5, "R8 toggle");
        // successful selection clears block number
        select_seq(8'd16, 8'd3, 2'd1, "R6 success");
        exchange(8'd5, 8'd3, 1'b0, 8'd3, "R6 block cleared");

        // R11: start while busy ignored
        begin
            int n;
            do_start(1'b1, 8'd2);
            collect(n);
            exp_blk = ~exp_blk;
            @(negedge clk);
            tx_ready_i = 1'b0;
            start_i = 1'b1; op_i = 1'b0;
            @(negedge clk);
            start_i = 1'b0;
            answer(8'd7, 1'b0, 1'b1);
            poll(w);
            check(w == 1 && resp_len_o == 8'd7, "R11 running exchange completes", resp_len_o, 7);
            repeat (4) @(negedge clk);
            #1;
            check(!busy_o && !tx_valid_o, "R11 no frame from ignored start", {busy_o, tx_valid_o}, 0);
        end

        // R12: frame and timeout in the same cycle
        begin
            int n;
            do_start(1'b1, 8'd1);
            collect(n);
            exp_blk = ~exp_blk;
            answer(8'd5, 1'b1, 1'b1);
            poll(w);
            check(w == 1 && resp_len_o == 8'd5, "R12 frame wins over timeout", resp_len_o, 5);
        end

        check(hold_err == 0, "R13 byte held during stall", hold_err, 0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nbad++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end
endmodule